// File: doc/BRIEF.md
# Multi-Mode Display Host Interface

This block is the host-facing bus front end of a display controller. Two strap inputs choose how the host talks to it. One strap picks the parallel port or a write-only serial link. The other picks one of two parallel signalling styles. The first style has separate active-low read and write strobes. The second has a high-active enable clock plus a read/write direction line. The block decodes the chip select, the strobes and the data/command select. Every completed host write becomes one internal write pulse that carries an 8-bit byte and a flag marking it as display data or a command.

On parallel reads, the block takes a byte from the core and drives it onto the pad data bus through an output-enable. In serial mode, two lines of the data bus carry the serial data and the serial clock, and the bus is never driven. Every host signal crosses into the internal clock domain through a two-stage synchronizer. The active-low host reset is synchronized as well and then handed on to the core as an active-high reset.

Top module: `disp_host_if`

## Requirements
- R1: While `hst_rst_n` is low, `core_rst` is high, `wr_valid` and `bus_oe` stay low, and the serial bit count is cleared, so bits shifted before the reset never join a later byte.
- R2: With `strap_par`=1 and `strap_m68`=0, a rising edge of `strb_b` (active-low write strobe) while `cs_n` is low yields one write carrying the value on `bus_i`.
- R3: With `strap_par`=1 and `strap_m68`=0, `bus_oe` is high and `bus_o` equals `rd_byte` while `cs_n` and `strb_a` (active-low read strobe) are both low. Otherwise `bus_oe` is low.
- R4: With `strap_par`=1 and `strap_m68`=1, a falling edge of `strb_a` (high-active enable) while `strb_b` (direction, 0 = write) is low and `cs_n` is low yields one write carrying `bus_i`.
- R5: With `strap_par`=1 and `strap_m68`=1, `bus_oe` is high and `bus_o` equals `rd_byte` while `cs_n` is low and both `strb_a` and `strb_b` are high.
- R6: `wr_is_data` equals the `dc_sel` level at the write: 1 means display data and 0 means a command.
- R7: With `strap_par`=0, `bus_i[7]` is serial data and `bus_i[6]` is the serial clock. Bits enter on rising clock edges, most significant bit first. After the 8th edge one write is produced, and its flag is `dc_sel` as sampled on that 8th edge.
- R8: With `strap_par`=0, `bus_oe` stays low for every strobe pattern.
- R9: While `cs_n` is high, strobe edges and serial clock edges produce no write, and `bus_oe` stays low.
- R10: Raising `cs_n` in the middle of a serial byte discards the bits received so far. The next byte starts again from bit 7.
- R11: Each completed write gives exactly one `wr_valid` pulse, one clock cycle long. The pulse arrives on the third rising clock edge after the completing host edge.
- R12: With `strap_m68`=1, a falling edge of the enable while the direction line is high (a read) produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| hst_rst_n | input | 1 | Host reset, active low, asynchronous |
| strap_m68 | input | 1 | Parallel style strap: 1 = enable + direction, 0 = separate read/write strobes |
| strap_par | input | 1 | Port strap: 1 = parallel, 0 = serial write-only |
| cs_n | input | 1 | Chip select, active low |
| dc_sel | input | 1 | 1 = display data, 0 = command |
| strb_a | input | 1 | Read strobe (active low) or enable (active high) |
| strb_b | input | 1 | Write strobe (active low) or direction (1 = read) |
| bus_i | input | 8 | Data bus as seen at the pads; bits 7 and 6 are data and clock in serial mode |
| bus_o | output | 8 | Read byte driven toward the pads |
| bus_oe | output | 1 | Output enable of the tristate data pads |
| rd_byte | input | 8 | Byte from the core to return on reads |
| wr_valid | output | 1 | One-cycle pulse per completed write |
| wr_byte | output | 8 | Byte of the latest write |
| wr_is_data | output | 1 | Flag of the latest write: 1 = data, 0 = command |
| core_rst | output | 1 | Synchronized active-high reset for the core |

## Verification
The bench fixes the pulse latency. A design that acted on the first synchronizer stage, or that registered the output twice, would raise `wr_valid` one cycle early or late. It would also produce a double pulse if the edge detection were level-based. The bench checks that a falling enable with the direction line high is not taken as a write, since a design that ignored the direction bit would invent bytes during reads. It aborts a serial byte both with chip select and with reset, which exposes a bit counter that was not cleared by showing a byte shifted by the stale bits. It also tries to provoke the bus into driving in serial mode and while chip select is high, where a missing gate would cause a bus fight.

// File: rtl/dhi_pkg.sv
package dhi_pkg;
  localparam int BYTE_W = 8;
  localparam int SDI_BIT = 7;
  localparam int SCK_BIT = 6;

  typedef enum logic [1:0] {
    BUS_I80 = 2'd0,
    BUS_M68 = 2'd1,
    BUS_SER = 2'd2
  } bus_mode_e;

  typedef struct packed {
    logic              vld;
    logic              is_data;
    logic [BYTE_W-1:0] byte_v;
  } wr_evt_t;
endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dhi_par_port.sv
module dhi_par_port
  import dhi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i80,
  input  logic              en_m68,
  input  logic              cs_n,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic              dc,
  input  logic [BYTE_W-1:0] din,
  output wr_evt_t           evt,
  output logic              oe_req
);
  logic a_q, b_q;
  logic i80_wr, m68_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= strb_a;
      b_q <= strb_b;
    end
  end

  // write strobe released: low -> high
  assign i80_wr = en_i80 && !cs_n && strb_b && !b_q;
  // enable dropped with direction = write
  assign m68_wr = en_m68 && !cs_n && !strb_a && a_q && !strb_b;

  always_comb begin
    evt.vld     = i80_wr || m68_wr;
    evt.is_data = dc;
    evt.byte_v  = din;
  end

  assign oe_req = !cs_n && ((en_i80 && !strb_a) || (en_m68 && strb_a && strb_b));

  // R12
  m68_rd_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (en_m68 && oe_req) |-> !evt.vld);
endmodule

// File: rtl/dhi_ser_port.sv
module dhi_ser_port
  import dhi_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    cs_n,
  input  logic    sclk,
  input  logic    sdi,
  input  logic    dc,
  output wr_evt_t evt
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic              sclk_q;
  logic [BYTE_W-2:0] sh;
  logic [CW-1:0]     cnt;
  logic              rise;

  assign rise = en && !cs_n && sclk && !sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      if (!en || cs_n) begin
        cnt <= '0;
      end else if (rise) begin
        sh  <= {sh[BYTE_W-3:0], sdi};
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end

  always_comb begin
    evt.vld     = rise && (cnt == LAST);
    evt.is_data = dc;
    evt.byte_v  = {sh, sdi};
  end

  // R10
  partial_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cnt == '0));
endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
  import dhi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hst_rst_n,
  input  logic              strap_m68,
  input  logic              strap_par,
  input  logic              cs_n,
  input  logic              dc_sel,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic [BYTE_W-1:0] bus_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              bus_oe,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_is_data,
  output logic              core_rst
);
  localparam int CTL_W = 6;
  localparam logic [CTL_W-1:0] CTL_IDLE = 6'b10_1011;

  logic              rstn_s;
  logic              rst_q;
  logic [CTL_W-1:0]  ctl_s;
  logic [BYTE_W-1:0] din_s;
  logic              par_s, m68_s, cs_s, dc_s, a_s, b_s;
  bus_mode_e         mode;
  wr_evt_t           par_evt, ser_evt, evt;
  logic              oe_req;

  // reset: synchronizer, then one register
  dhi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst(1'b0), .d(hst_rst_n), .q(rstn_s)
  );

  always_ff @(posedge clk) rst_q <= !rstn_s;
  assign core_rst = rst_q;

  dhi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_csync (
    .clk(clk), .rst(rst_q),
    .d({strap_par, strap_m68, cs_n, dc_sel, strb_a, strb_b}),
    .q(ctl_s)
  );

  dhi_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dsync (
    .clk(clk), .rst(rst_q), .d(bus_i), .q(din_s)
  );

  assign {par_s, m68_s, cs_s, dc_s, a_s, b_s} = ctl_s;

  always_comb begin
    if (!par_s)     mode = BUS_SER;
    else if (m68_s) mode = BUS_M68;
    else            mode = BUS_I80;
  end

  dhi_par_port u_par (
    .clk(clk), .rst(rst_q),
    .en_i80(mode == BUS_I80), .en_m68(mode == BUS_M68),
    .cs_n(cs_s), .strb_a(a_s), .strb_b(b_s), .dc(dc_s), .din(din_s),
    .evt(par_evt), .oe_req(oe_req)
  );

  dhi_ser_port u_ser (
    .clk(clk), .rst(rst_q), .en(mode == BUS_SER), .cs_n(cs_s),
    .sclk(din_s[SCK_BIT]), .sdi(din_s[SDI_BIT]), .dc(dc_s),
    .evt(ser_evt)
  );

  assign evt = (mode == BUS_SER) ? ser_evt : par_evt;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      wr_valid   <= 1'b0;
      wr_byte    <= '0;
      wr_is_data <= 1'b0;
      bus_oe     <= 1'b0;
      bus_o      <= '0;
    end else begin
      wr_valid <= evt.vld;
      if (evt.vld) begin
        wr_byte    <= evt.byte_v;
        wr_is_data <= evt.is_data;
      end
      bus_oe <= oe_req && (mode != BUS_SER);
      bus_o  <= rd_byte;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst_q |=> (!wr_valid && !bus_oe));
  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst_q)
    wr_valid |=> !wr_valid);
  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst_q)
    cs_s |=> (!wr_valid && !bus_oe));
  // R8
  ser_quiet_chk: assert property (@(posedge clk) disable iff (rst_q)
    (mode == BUS_SER) |=> !bus_oe);
endmodule

// File: tb/tb_disp_host_if.sv
module tb_disp_host_if;
  logic       clk = 1'b0;
  logic       hst_rst_n = 1'b0;
  logic       strap_m68 = 1'b0, strap_par = 1'b1;
  logic       cs_n = 1'b1, dc_sel = 1'b0, strb_a = 1'b1, strb_b = 1'b1;
  logic [7:0] bus_i = 8'h00, rd_byte = 8'h00;
  logic [7:0] bus_o, wr_byte;
  logic       bus_oe, wr_valid, wr_is_data, core_rst;

  int vectors = 0, miscompares = 0;
  int pulses = 0, dbl = 0;
  logic [7:0] last_byte = 8'h00;
  logic last_dc = 1'b0, prev_wv = 1'b0;

  always #4 clk = ~clk;

  disp_host_if dut (
    .clk(clk), .hst_rst_n(hst_rst_n), .strap_m68(strap_m68), .strap_par(strap_par),
    .cs_n(cs_n), .dc_sel(dc_sel), .strb_a(strb_a), .strb_b(strb_b),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .rd_byte(rd_byte),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_is_data(wr_is_data), .core_rst(core_rst)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      pulses++;
      last_byte = wr_byte;
      last_dc = wr_is_data;
      if (prev_wv) dbl++;
    end
    prev_wv = wr_valid;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 = strobe pair, 1 = enable + direction, 2 = serial
  task automatic set_mode(input int m);
    @(negedge clk);
    cs_n = 1'b1;
    strap_par = (m != 2);
    strap_m68 = (m == 1);
    strb_a = (m != 1);
    strb_b = 1'b1;
    bus_i[6] = 1'b0;
    cyc(5);
  endtask

  task automatic wr_i80(input logic dc, input logic [7:0] b);
    cs_n = 1'b0; dc_sel = dc; bus_i = b; cyc(3);
    strb_b = 1'b0; cyc(4);
    strb_b = 1'b1; cyc(5);
    cs_n = 1'b1; cyc(3);
  endtask

  task automatic wr_m68(input logic dc, input logic [7:0] b);
    cs_n = 1'b0; dc_sel = dc; bus_i = b; strb_b = 1'b0; cyc(3);
    strb_a = 1'b1; cyc(4);
    strb_a = 1'b0; cyc(5);
    strb_b = 1'b1; cs_n = 1'b1; cyc(3);
  endtask

  task automatic ser_bits(input logic dc, input logic [7:0] b, input int n);
    cs_n = 1'b0; dc_sel = dc; bus_i[5:0] = 6'h3F; cyc(3);
    for (int i = 7; i > 7 - n; i--) begin
      bus_i[7] = b[i]; bus_i[6] = 1'b0; cyc(3);
      bus_i[6] = 1'b1; cyc(3);
    end
    bus_i[6] = 1'b0; cyc(4);
  endtask

  // {mode[1:0], dc, byte}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b1, 8'hA5}, {2'd0, 1'b0, 8'h01}, {2'd1, 1'b1, 8'h5A}, {2'd1, 1'b0, 8'hFF},
    {2'd2, 1'b1, 8'h96}, {2'd2, 1'b0, 8'h80}, {2'd2, 1'b1, 8'h01}, {2'd0, 1'b0, 8'h00}
  };

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int p0;
    cyc(6);
    // R1 reset state
    check("R1 core_rst", core_rst, 1);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 bus_oe", bus_oe, 0);
    hst_rst_n = 1'b1; cyc(6);
    check("R1 core_rst released", core_rst, 0);

    // table: R2 / R4 / R7 writes with R6 flag
    for (int v = 0; v < 8; v++) begin
      set_mode(int'(VEC[v][10:9]));
      p0 = pulses;
      case (VEC[v][10:9])
        2'd0: wr_i80(VEC[v][8], VEC[v][7:0]);
        2'd1: wr_m68(VEC[v][8], VEC[v][7:0]);
        default: begin ser_bits(VEC[v][8], VEC[v][7:0], 8); cs_n = 1'b1; cyc(3); end
      endcase
      check("R2/R4/R7 pulse count", pulses - p0, 1);
      check("R2/R4/R7 byte", last_byte, VEC[v][7:0]);
      check("R6 flag", last_dc, VEC[v][8]);
    end

    // R11 exact latency and single-cycle pulse
    set_mode(0);
    cs_n = 1'b0; dc_sel = 1'b1; bus_i = 8'hC3; cyc(3);
    strb_b = 1'b0; cyc(4);
    strb_b = 1'b1; cyc(1);
    check("R11 edge+1", wr_valid, 0); cyc(1);
    check("R11 edge+2", wr_valid, 0); cyc(1);
    check("R11 edge+3", wr_valid, 1); cyc(1);
    check("R11 edge+4", wr_valid, 0);
    cs_n = 1'b1; cyc(3);

    // R3 read in strobe-pair mode
    rd_byte = 8'h3C;
    cs_n = 1'b0; strb_a = 1'b0; cyc(5);
    check("R3 oe during read", bus_oe, 1);
    check("R3 read byte", bus_o, 8'h3C);
    strb_a = 1'b1; cyc(5);
    check("R3 oe after read", bus_oe, 0);
    cs_n = 1'b1; cyc(3);

    // R9 chip select high ignores strobes
    p0 = pulses;
    strb_b = 1'b0; cyc(4); strb_b = 1'b1; cyc(6);
    check("R9 no write with cs high", pulses - p0, 0);
    strb_a = 1'b0; cyc(5);
    check("R9 no drive with cs high", bus_oe, 0);
    strb_a = 1'b1; cyc(3);

    // R5 / R12 enable + direction read
    set_mode(1);
    rd_byte = 8'hE7; p0 = pulses;
    cs_n = 1'b0; strb_b = 1'b1; cyc(2); strb_a = 1'b1; cyc(5);
    check("R5 oe during read", bus_oe, 1);
    check("R5 read byte", bus_o, 8'hE7);
    strb_a = 1'b0; cyc(6);
    check("R5 oe after read", bus_oe, 0);
    check("R12 read edge not a write", pulses - p0, 0);
    cs_n = 1'b1; cyc(3);

    // R8 serial never drives
    set_mode(2);
    cs_n = 1'b0; strb_a = 1'b0; cyc(5);
    check("R8 oe low, read-like strobe", bus_oe, 0);
    strb_a = 1'b1; strb_b = 1'b1; cyc(5);
    check("R8 oe low, enable-like strobe", bus_oe, 0);
    cs_n = 1'b1; cyc(3);

    // R10 partial byte dropped by chip select
    p0 = pulses;
    ser_bits(1'b0, 8'hFF, 3);
    cs_n = 1'b1; cyc(4);
    ser_bits(1'b1, 8'h3C, 8); cs_n = 1'b1; cyc(3);
    check("R10 one byte", pulses - p0, 1);
    check("R10 byte realigned", last_byte, 8'h3C);

    // R1 partial byte dropped by reset
    p0 = pulses;
    ser_bits(1'b0, 8'hFF, 5);
    cs_n = 1'b1; hst_rst_n = 1'b0; cyc(5);
    hst_rst_n = 1'b1; cyc(6);
    ser_bits(1'b0, 8'h69, 8); cs_n = 1'b1; cyc(3);
    check("R1 byte after reset", last_byte, 8'h69);
    check("R1 one byte after reset", pulses - p0, 1);

    check("R11 no double pulses", dbl, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule